// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-clock request port to an external asynchronous static RAM with a 16-bit shared data bus. The RAM has active-low strobes for chip select, output enable and write enable, plus one active-low enable for each byte lane. A requester presents a read or a write with an 18-bit word address, write data and a two-bit lane mask, using a valid/ready handshake. The controller then drives the strobe pins in a fixed sequence. Each phase lasts a whole number of clock cycles, and every count is found by dividing a nanosecond limit by the clock period and rounding up. A read returns its data with a single-cycle valid pulse.

Writes are controlled by write enable. The address, chip select and lane enables are set up first. Write enable then pulses low, and it rises while the rest stay held for a hold phase. Reads keep output enable and chip select low for the full access time, and the data is sampled at the edge that closes that window. Lanes that are not selected in the mask read back as zero.

The pad ring sits outside this block. The bus appears as separate drive-data, drive-enable and sampled-input vectors. After a read, the controller holds off its own drivers until the RAM's output float time has passed.

Top module: `sram_lane_ctl`

## Requirements
- R1: After reset `req_ready` is 1, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_be_n` is all ones, `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A read with a non-empty mask holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with a stable address for exactly RD cycles. RD is the largest of ceil(70/P), ceil(70/P) and ceil(35/P) for clock period P ns (14 at P=5). `rsp_valid` is 1 for one cycle, RD+1 cycles after the accepting edge, and it carries the data that the RAM drove at the end of that window.
- R3: A write with a non-empty mask holds `sram_ce_n`=0 with a stable address for SU+WP+HD cycles. During the SU setup cycles `sram_we_n`=1, during the WP cycles `sram_we_n`=0, and during the HD cycles `sram_we_n`=1 again with address, chip select and lane enables unchanged. WP=ceil(50/P), SU=max(1, ceil(60/P)-WP, ceil(30/P)-WP) and HD=max(1, ceil(70/P)-SU-WP), which gives 2/10/2 at P=5. `sram_dq_oe` is 1 with `sram_dq_o` equal to the write data over all those cycles. Write enable is never low unless chip select and at least one lane enable are also low.
- R4: Mask bit 0 selects the low lane (data bits 7..0, `sram_be_n[0]`) and mask bit 1 selects the high lane (bits 15..8, `sram_be_n[1]`). A write changes only the lanes that are selected.
- R5: In a read response, the bits of any lane whose mask bit is 0 are 0, whatever the bus carries.
- R6: `req_ready` is 0 from the cycle after an access is accepted until the access completes. Whenever `req_ready` is 1, chip select is deasserted and the data drivers are off.
- R7: `sram_dq_oe` is never 1 while the RAM may still drive the bus. That covers any cycle with `sram_oe_n`=0 and the TURN=ceil(25/P) cycles after output enable rises (5 at P=5). A write accepted in the first cycle after a read completes first drives TURN cycles after its accepting edge. A write accepted right after a write first drives 1 cycle after its accepting edge.
- R8: A request with mask 00 is accepted in the same cycle and causes no strobe activity. For a read, `rsp_valid` rises one cycle later with data 0. A write with mask 00 leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_be_n | output | 2 | RAM lane enables, active low, bit 0 = low lane |
| sram_dq_o | output | 16 | Data to the bus pads |
| sram_dq_oe | output | 1 | Pad drive enable |
| sram_dq_i | input | 16 | Data sampled from the bus pads |

## Verification
The hardest case to reach is a write that arrives exactly as a read ends. Only then does the float window overlap the point where the controller could start driving. The bench queues the write during the read, so it is accepted in the first idle cycle. A RAM model inside the bench keeps driving junk for the float time after output enable rises and flags any cycle in which both sides drive. The same model returns junk until the access time has elapsed, so a read window that is too short shows up as wrong data.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RD    = 3'd1,
        PH_GAP   = 3'd2,
        PH_SETUP = 3'd3,
        PH_PULSE = 3'd4,
        PH_HOLD  = 3'd5
    } phase_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns2cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_tmr.sv
`timescale 1ns/1ps
module sram_phase_tmr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/sram_lane_map.sv
`timescale 1ns/1ps
module sram_lane_map #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data[g*LANE_W +: LANE_W] = mask[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_rsp_reg.sv
`timescale 1ns/1ps
module sram_rsp_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_rd,
    input  logic              cap_zero,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t d, q;

    always_comb begin
        d     = q;
        d.vld = cap_rd | cap_zero;
        if (cap_rd) begin
            d.data = rd_data;
        end else if (cap_zero) begin
            d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.vld;
    assign rsp_rdata = q.data;

    AST_RSP_SOURCE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_rd && cap_zero)); // R8

endmodule

// File: rtl/sram_lane_ctl.sv
`timescale 1ns/1ps
module sram_lane_ctl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int LANE_W        = 8,
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_DW_NS       = 30,
    parameter int T_WC_NS       = 70,
    parameter int T_OHZ_NS      = 25,
    localparam int DATA_W       = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    // phase lengths in cycles
    localparam int RD_CYC   = imax(imax(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                        ns2cyc(T_AA_NS, CLK_PERIOD_NS)),
                                   ns2cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int WP_CYC   = imax(1, ns2cyc(T_WP_NS, CLK_PERIOD_NS));
    localparam int SU_CYC   = imax(1, imax(ns2cyc(T_AW_NS, CLK_PERIOD_NS) - WP_CYC,
                                           ns2cyc(T_DW_NS, CLK_PERIOD_NS) - WP_CYC));
    localparam int HD_CYC   = imax(1, ns2cyc(T_WC_NS, CLK_PERIOD_NS) - SU_CYC - WP_CYC);
    localparam int TURN_CYC = imax(1, ns2cyc(T_OHZ_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(imax(SU_CYC, HD_CYC), TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SU   = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HD   = CNT_W'(HD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  be_n;
        logic              dq_oe;
    } ctl_t;

    ctl_t d, q;

    logic [CNT_W-1:0]  ph_cnt;
    logic [CNT_W-1:0]  turn_cnt;
    logic [CNT_W-1:0]  ph_load_val;
    logic              ph_load;
    logic              turn_load;
    logic              cap_rd;
    logic              cap_zero;
    logic              ph_last;
    logic              pins_act;
    logic [DATA_W-1:0] rd_lanes;

    assign ph_last = (ph_cnt == '0);

    always_comb begin
        d           = q;
        ph_load     = 1'b0;
        ph_load_val = '0;
        turn_load   = 1'b0;
        cap_rd      = 1'b0;
        cap_zero    = 1'b0;

        unique case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_mask == '0) begin
                        // nothing to touch on the pins
                        cap_zero = !req_write;
                    end else begin
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.mask  = req_mask;
                        ph_load = 1'b1;
                        if (!req_write) begin
                            d.ph        = PH_RD;
                            ph_load_val = LD_RD;
                        end else if (turn_cnt > CNT_W'(1)) begin
                            // this idle cycle is one float cycle already
                            d.ph        = PH_GAP;
                            ph_load_val = turn_cnt - CNT_W'(2);
                        end else begin
                            d.ph        = PH_SETUP;
                            ph_load_val = LD_SU;
                        end
                    end
                end
            end
            PH_RD: begin
                if (ph_last) begin
                    cap_rd    = 1'b1;
                    turn_load = 1'b1;
                    d.ph      = PH_IDLE;
                end
            end
            PH_GAP: begin
                if (ph_last) begin
                    d.ph        = PH_SETUP;
                    ph_load     = 1'b1;
                    ph_load_val = LD_SU;
                end
            end
            PH_SETUP: begin
                if (ph_last) begin
                    d.ph        = PH_PULSE;
                    ph_load     = 1'b1;
                    ph_load_val = LD_WP;
                end
            end
            PH_PULSE: begin
                if (ph_last) begin
                    d.ph        = PH_HOLD;
                    ph_load     = 1'b1;
                    ph_load_val = LD_HD;
                end
            end
            PH_HOLD: begin
                if (ph_last) begin
                    d.ph = PH_IDLE;
                end
            end
            default: begin
                d.ph = PH_IDLE;
            end
        endcase

        // pin levels for the coming cycle follow the next phase
        pins_act = (d.ph == PH_RD) || (d.ph == PH_SETUP) ||
                   (d.ph == PH_PULSE) || (d.ph == PH_HOLD);
        d.ce_n   = !pins_act;
        d.oe_n   = (d.ph != PH_RD);
        d.we_n   = (d.ph != PH_PULSE);
        d.dq_oe  = (d.ph == PH_SETUP) || (d.ph == PH_PULSE) || (d.ph == PH_HOLD);
        for (int i = 0; i < LANES; i++) begin
            d.be_n[i] = !(pins_act && d.mask[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, addr: '0, wdata: '0, mask: '0, ce_n: 1'b1,
                   oe_n: 1'b1, we_n: 1'b1, be_n: '1, dq_oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    sram_phase_tmr #(.CNT_W(CNT_W)) u_ph_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_load_val),
        .cnt      (ph_cnt)
    );

    sram_phase_tmr #(.CNT_W(CNT_W)) u_turn_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (turn_load),
        .load_val (LD_TURN),
        .cnt      (turn_cnt)
    );

    sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lane_map (
        .mask    (q.mask),
        .dq_i    (sram_dq_i),
        .rd_data (rd_lanes)
    );

    sram_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_rd    (cap_rd),
        .cap_zero  (cap_zero),
        .rd_data   (rd_lanes),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready  = (q.ph == PH_IDLE);
    assign sram_addr  = q.addr;
    assign sram_ce_n  = q.ce_n;
    assign sram_oe_n  = q.oe_n;
    assign sram_we_n  = q.we_n;
    assign sram_be_n  = q.be_n;
    assign sram_dq_o  = q.wdata;
    assign sram_dq_oe = q.dq_oe;

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n && !sram_dq_oe)); // R2

    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && (sram_be_n != '1))); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R3

    AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && $stable(sram_be_n))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !sram_dq_oe)); // R6

    AST_FLOAT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (turn_cnt == '0)); // R7

endmodule

// File: tb/tb_sram_lane_ctl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctl;

    localparam int P    = 5;
    localparam int RD   = 14;  // ceil(70/5)
    localparam int WP   = 10;  // ceil(50/5)
    localparam int SU   = 2;   // max(1, 12-10, 6-10)
    localparam int HD   = 2;   // max(1, 14-2-10)
    localparam int TURN = 5;   // ceil(25/5)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_lane_ctl #(.CLK_PERIOD_NS(P)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    bit [15:0] mem [int];
    bit [15:0] shadow [int];
    int   rd_age = 0;
    int   float_cnt = 0;
    int   ce_run = 0;
    bit   run_wr = 0;
    int   we_low = 0;
    int   dstab = 0;
    logic prev_we = 1'b1;
    logic [15:0] prev_dq = '0;
    logic [17:0] prev_addr = '0;
    logic [1:0]  prev_be = 2'b11;
    logic        prev_rd = 1'b0;
    logic [17:0] snap_addr = '0;
    logic [1:0]  snap_be = 2'b11;
    logic [15:0] snap_dq = '0;
    int   snap_dstab = 0;
    int   snap_run = 0;
    logic rd_live;
    logic [15:0] model_dq;
    logic        model_drv;

    function automatic bit [15:0] mem_rd(input logic [17:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    function automatic bit [15:0] shadow_rd(input logic [17:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    endfunction

    always @* begin
        rd_live   = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_be_n != 2'b11);
        model_drv = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (rd_live && !sram_be_n[i]) begin
                model_drv = 1'b1;
                model_dq[i*8 +: 8] = (rd_age * P >= 70) ? mem_rd(sram_addr)[i*8 +: 8] : 8'hA5;
            end else if (float_cnt > 0) begin
                model_drv = 1'b1;
                model_dq[i*8 +: 8] = 8'hC3;
            end else begin
                model_dq[i*8 +: 8] = 8'h5A;
            end
        end
        sram_dq_i = sram_dq_oe ? sram_dq_o : model_dq;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && model_drv)
                chk(1'b0, "R7 bus conflict", {16'h0, sram_dq_o}, 32'h0);
            // read access age
            if (rd_live && prev_rd && sram_addr == prev_addr && sram_be_n == prev_be)
                rd_age = rd_age + 1;
            else
                rd_age = rd_live ? 1 : 0;
            // output float tail
            if (rd_live) float_cnt = TURN;
            else if (float_cnt > 0) float_cnt = float_cnt - 1;
            // chip select run
            if (!sram_ce_n) begin
                if (ce_run > 0 && sram_addr != prev_addr)
                    chk(1'b0, "R3 address moved while selected", {14'h0, sram_addr}, {14'h0, prev_addr});
                ce_run = ce_run + 1;
            end else if (ce_run > 0) begin
                chk(ce_run == (run_wr ? SU + WP + HD : RD),
                    run_wr ? "R3 write select length" : "R2 read select length",
                    ce_run, run_wr ? SU + WP + HD : RD);
                ce_run = 0;
                run_wr = 0;
            end
            // data stability
            if (sram_dq_oe) dstab = (dstab > 0 && sram_dq_o == prev_dq) ? dstab + 1 : 1;
            else dstab = 0;
            // write strobe
            if (!sram_we_n) begin
                if (sram_ce_n || sram_be_n == 2'b11)
                    chk(1'b0, "R3 write strobe without select", {30'h0, sram_be_n}, 32'h0);
                run_wr     = 1;
                we_low     = we_low + 1;
                snap_addr  = sram_addr;
                snap_be    = sram_be_n;
                snap_dq    = sram_dq_o;
                snap_dstab = dstab;
                snap_run   = ce_run;
            end else if (!prev_we) begin
                chk(we_low == WP, "R3 write pulse length", we_low, WP);
                chk(snap_run == SU + WP, "R3 setup plus pulse", snap_run, SU + WP);
                chk(snap_dstab * P >= 30, "R3 data setup", snap_dstab, 6);
                chk(!sram_ce_n && sram_addr == snap_addr && sram_be_n == snap_be,
                    "R3 hold after strobe", {14'h0, sram_addr}, {14'h0, snap_addr});
                begin
                    bit [15:0] w;
                    w = mem_rd(snap_addr);
                    if (!snap_be[0]) w[7:0]  = snap_dq[7:0];
                    if (!snap_be[1]) w[15:8] = snap_dq[15:8];
                    mem[int'(snap_addr)] = w;
                end
                we_low = 0;
            end
            prev_we   = sram_we_n;
            prev_dq   = sram_dq_o;
            prev_addr = sram_addr;
            prev_be   = sram_be_n;
            prev_rd   = rd_live;
        end
    end

    // ---------------- request helpers ----------------
    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] dat, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic bit [15:0] merge(input bit [15:0] old, input bit [15:0] dat, input logic [1:0] m);
        bit [15:0] r;
        r = old;
        if (m[0]) r[7:0]  = dat[7:0];
        if (m[1]) r[15:8] = dat[15:8];
        return r;
    endfunction

    task automatic do_write(input logic [17:0] a, input logic [15:0] dat, input logic [1:0] m);
        issue(1'b1, a, dat, m);
        if (m != 2'b00) chk(!req_ready, "R6 ready low during write", req_ready, 0);
        shadow[int'(a)] = merge(shadow_rd(a), dat, m);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m, input string tag);
        int lat;
        bit [15:0] e;
        e = merge(16'h0, shadow_rd(a), m);
        issue(1'b0, a, 16'h0, m);
        chk(!req_ready, "R6 ready low during read", req_ready, 0);
        lat = 1;
        while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == RD + 1, "R2 read latency", lat, RD + 1);
        chk(rsp_rdata == e, tag, rsp_rdata, e);
        @(negedge clk);
        chk(!rsp_valid, "R2 response is one cycle", rsp_valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1 strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        chk(sram_be_n == 2'b11, "R1 lane enables", sram_be_n, 2'b11);
        chk(!sram_dq_oe && !rsp_valid, "R1 drive and response", {sram_dq_oe, rsp_valid}, 0);
    endtask

    task automatic t_full_words();
        do_write(18'h00000, 16'h1234, 2'b11);
        do_write(18'h3FFFF, 16'hBEEF, 2'b11);
        do_read(18'h00000, 2'b11, "R2 full word at address 0");
        do_read(18'h3FFFF, 2'b11, "R2 full word at top address");
        for (int k = 0; k < 6; k++) begin
            logic [17:0] a;
            a = 18'(k * 18'h0A5A5 + 7);
            do_write(a, 16'(16'h9E37 * (k + 1)), 2'b11);
            do_read(a, 2'b11, "R2 pattern word");
        end
    endtask

    task automatic t_lanes();
        do_write(18'h00100, 16'hFFFF, 2'b11);
        do_write(18'h00100, 16'h1234, 2'b01);
        do_read(18'h00100, 2'b11, "R4 low lane write only");
        do_write(18'h00100, 16'hABCD, 2'b10);
        do_read(18'h00100, 2'b11, "R4 high lane write only");
        do_read(18'h00100, 2'b01, "R5 low lane read, high zero");
        do_read(18'h00100, 2'b10, "R5 high lane read, low zero");
    endtask

    task automatic t_turnaround();
        int cnt;
        bit got;
        do_write(18'h00200, 16'h5555, 2'b11);
        issue(1'b0, 18'h00200, 16'h0, 2'b11);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00201;
        req_wdata = 16'h7E7E; req_mask = 2'b11;
        got = 0;
        while (!req_ready) @(negedge clk);
        got = rsp_valid;
        chk(got && rsp_rdata == 16'h5555, "R2 read before turnaround", rsp_rdata, 16'h5555);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        shadow[int'(18'h00201)] = 16'h7E7E;
        cnt = 1;
        while (!sram_dq_oe && cnt < 100) begin @(negedge clk); cnt++; end
        chk(cnt == TURN, "R7 drive delay after read", cnt, TURN);
        while (!req_ready) @(negedge clk);
        issue(1'b1, 18'h00202, 16'h0F0F, 2'b11);
        shadow[int'(18'h00202)] = 16'h0F0F;
        chk(sram_dq_oe, "R7 no gap after write", sram_dq_oe, 1);
        while (!req_ready) @(negedge clk);
        do_read(18'h00201, 2'b11, "R7 word written after turnaround");
    endtask

    task automatic t_empty_mask();
        int lat;
        bit quiet;
        do_write(18'h00300, 16'hC0DE, 2'b11);
        issue(1'b1, 18'h00300, 16'h1111, 2'b00);
        quiet = 1;
        for (int k = 0; k < 4; k++) begin
            if (!sram_ce_n || !sram_we_n || !req_ready) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R8 empty write leaves pins idle", quiet, 1);
        do_read(18'h00300, 2'b11, "R8 empty write leaves word unchanged");
        issue(1'b0, 18'h00300, 16'h0, 2'b00);
        lat = 1;
        chk(rsp_valid && rsp_rdata == 16'h0, "R8 empty read responds next cycle with zero", {rsp_valid, rsp_rdata}, 32'h10000);
        chk(sram_ce_n, "R8 empty read leaves pins idle", sram_ce_n, 1);
        @(negedge clk);
        chk(!rsp_valid, "R8 empty read pulse ends", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_words();
        t_lanes();
        t_turnaround();
        t_empty_mask();
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule